// File: doc/BRIEF.md
# Multiprocessor Device Interrupt Router

This block sends up to 64 device interrupt lines to four processors. Devices set and clear single bits of a shared raw request vector through two strobe ports. Each processor has its own enable mask. The router keeps a per-processor request register that always equals that processor's mask ANDed with the raw vector. Each processor gets one level-sensitive interrupt output, and that output is high whenever its request register is non-zero.

Software reaches the block through a 64-bit register channel. The request side is a valid/ready channel. The block accepts a request on a cycle where `req_valid` and `req_ready` are both high. The response side is also valid/ready and gives exactly one response per accepted request. A response stays valid and keeps its data and error bit unchanged until the consumer raises `rsp_ready`. `req_ready` is low while an unconsumed response is pending and the consumer is not taking it. So the consumer applies back-pressure simply by holding `rsp_ready` low.

Registers sit on 64-byte strides. Only full 64-bit accesses are legal. The masks are the only writable registers. Every illegal access is refused, reported in its response and recorded in a sticky flag.

Top module: `irq_router`

## Requirements
- R1: After reset every mask, request register, raw bit and the error flag read zero, all `cpu_irq` bits are low, `rsp_valid` is low and `req_ready` is high.
- R2: The register index is `req_addr[ADDR_W-1:6]`, and the low six address bits are ignored. Index n in 0..3 is the mask of CPU n (read/write). Index 4+n is the request register of CPU n (read only). Index 8 is the raw vector (read only). Index 9 holds the sticky error flag in bit 0 (read only).
- R3: The request register of CPU n equals mask n AND the raw vector. It takes its new value on the same clock edge as the mask write or raw-line change that alters it.
- R4: A `line_set` strobe sets raw bit `line_set_idx`, and a `line_clr` strobe clears raw bit `line_clr_idx`. When both strobes name the same line in one cycle, the set wins.
- R5: Clearing a raw line that is already zero is spurious. It leaves the raw vector and every request register unchanged.
- R6: `cpu_irq[n]` is high exactly one cycle after request register n is non-zero. So enabling a mask bit for a pending line posts the interrupt, clearing it withdraws the interrupt, and raising a line interrupts every CPU whose mask enables it.
- R7: Only size code 3 (8 bytes) on `req_size` is legal. Any other size is an illegal access.
- R8: Writes to indices 4 to 9, and any access to an index above 9, are illegal. An illegal access changes no mask or raw state, and its response carries data 0 with `rsp_err` high.
- R9: The error flag becomes 1 on the first illegal access and stays 1 until reset, whatever legal accesses follow.
- R10: One response is produced per accepted request, in order. A write response carries data 0. A stalled response holds `rsp_valid`, `rsp_data` and `rsp_err` stable, and no new request is accepted while it is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request offered |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code, 3 = 8 bytes |
| req_addr | input | ADDR_W (12) | Byte offset within the block |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 64 | Read data, 0 for writes and illegal accesses |
| rsp_err | output | 1 | Access was illegal |
| line_set | input | 1 | Set one raw request line |
| line_set_idx | input | 6 | Line to set |
| line_clr | input | 1 | Clear one raw request line |
| line_clr_idx | input | 6 | Line to clear |
| cpu_irq | output | 4 | Per-CPU device interrupt level |

## Verification
The bench targets the transitions where a router that keeps only edge history would go wrong. One case enables a mask bit for a line that is already pending; a design that posts only on raw-line edges would leave the CPU silent. Another case clears a mask bit while its line is active, which must withdraw the interrupt. It also lowers a line seen by several CPUs, and issues a spurious clear that must not disturb anything. A set and a clear of the same line in one cycle shows whether the priority is reversed. Illegal sizes, writes to read-only registers and unmapped reads must leave every mask intact and latch the error flag. A stalling consumer shows whether responses get dropped, duplicated or changed while they are held.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // access size codes on the register channel
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  // which register family an index falls into
  typedef enum logic [2:0] {
    RK_MASK = 3'd0,
    RK_REQ  = 3'd1,
    RK_RAW  = 3'd2,
    RK_ERR  = 3'd3,
    RK_NONE = 3'd4
  } reg_kind_e;

  // registers are spaced on 64-byte strides
  localparam int unsigned STRIDE_LSB = 6;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int IDX_W   = 6,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             is_write,
  input  logic [1:0]       size,
  output reg_kind_e        kind,
  output logic [CPU_W-1:0] cpu_sel,
  output logic             legal
);

  localparam logic [IDX_W-1:0] REQ_BASE = IDX_W'(NUM_CPU);
  localparam logic [IDX_W-1:0] RAW_IDX  = IDX_W'(2 * NUM_CPU);
  localparam logic [IDX_W-1:0] ERR_IDX  = IDX_W'(2 * NUM_CPU + 1);

  logic [IDX_W-1:0] off;

  always_comb begin
    kind = RK_NONE;
    off  = '0;
    if (reg_idx < REQ_BASE) begin
      kind = RK_MASK;
      off  = reg_idx;
    end else if (reg_idx < RAW_IDX) begin
      kind = RK_REQ;
      off  = reg_idx - REQ_BASE;
    end else if (reg_idx == RAW_IDX) begin
      kind = RK_RAW;
    end else if (reg_idx == ERR_IDX) begin
      kind = RK_ERR;
    end
  end

  assign cpu_sel = CPU_W'(off);

  // only full-width accesses; only the masks take writes
  assign legal = (size == SZ_DWORD) && (kind != RK_NONE) &&
                 (!is_write || (kind == RK_MASK));

endmodule

// File: rtl/irq_raw_vector.sv
module irq_raw_vector #(
  parameter int NUM_LINES = 64,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [LINE_W-1:0]    set_idx,
  input  logic                 clr_en,
  input  logic [LINE_W-1:0]    clr_idx,
  output logic [NUM_LINES-1:0] raw_d,
  output logic [NUM_LINES-1:0] raw_q
);

  // clear first, then set, so a set wins on the same line
  always_comb begin
    raw_d = raw_q;
    if (clr_en) raw_d[clr_idx] = 1'b0;
    if (set_en) raw_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  // R4: a set strobe always lands
  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> raw_q[$past(set_idx)]);

  // R4: a lone clear always clears its line
  a_r4_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !raw_q[$past(clr_idx)]);

  // R5: clearing an idle line leaves the vector alone
  a_r5_spurious_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && !raw_q[clr_idx]) |=> (raw_q == $past(raw_q)));

endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] raw_d,
  input  logic [NUM_LINES-1:0] raw_q,
  output logic [NUM_LINES-1:0] mask_q,
  output logic [NUM_LINES-1:0] req_q,
  output logic                 irq_q
);

  logic [NUM_LINES-1:0] mask_d;

  assign mask_d = mask_we ? wdata : mask_q;

  // request is rebuilt from the next mask and next raw on every edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      req_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      req_q  <= mask_d & raw_d;
      irq_q  <= |req_q;
    end
  end

  // R3: stored request matches stored mask and raw vector
  a_r3_req_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    req_q == (mask_q & raw_q));

  // R6: output follows the request register one cycle later
  a_r6_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (|$past(req_q)));

  // R2: a mask write lands exactly as written
  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU   = 4,
  parameter int NUM_LINES = 64,
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [1:0]                   req_size,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [DATA_W-1:0]            rsp_data,
  output logic                         rsp_err,
  input  logic                         line_set,
  input  logic [$clog2(NUM_LINES)-1:0] line_set_idx,
  input  logic                         line_clr,
  input  logic [$clog2(NUM_LINES)-1:0] line_clr_idx,
  output logic [NUM_CPU-1:0]           cpu_irq
);

  localparam int IDX_W = ADDR_W - STRIDE_LSB;
  localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  logic                                acc;
  logic                                legal;
  reg_kind_e                           kind;
  logic [CPU_W-1:0]                    cpu_sel;
  logic [NUM_CPU-1:0]                  mask_we;
  logic [NUM_LINES-1:0]                raw_d;
  logic [NUM_LINES-1:0]                raw_q;
  logic [NUM_CPU-1:0][NUM_LINES-1:0]   mask_arr;
  logic [NUM_CPU-1:0][NUM_LINES-1:0]   req_arr;
  logic [DATA_W-1:0]                   rdata;
  logic                                err_q;
  logic                                unused_addr_low;

  assign unused_addr_low = ^req_addr[STRIDE_LSB-1:0];

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  irq_reg_decode #(
    .NUM_CPU (NUM_CPU),
    .IDX_W   (IDX_W)
  ) u_dec (
    .reg_idx  (req_addr[ADDR_W-1:STRIDE_LSB]),
    .is_write (req_write),
    .size     (req_size),
    .kind     (kind),
    .cpu_sel  (cpu_sel),
    .legal    (legal)
  );

  irq_raw_vector #(
    .NUM_LINES (NUM_LINES)
  ) u_raw (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (line_set),
    .set_idx (line_set_idx),
    .clr_en  (line_clr),
    .clr_idx (line_clr_idx),
    .raw_d   (raw_d),
    .raw_q   (raw_q)
  );

  for (genvar n = 0; n < NUM_CPU; n++) begin : g_cpu
    assign mask_we[n] = acc && req_write && legal &&
                        (kind == RK_MASK) && (cpu_sel == CPU_W'(n));

    irq_cpu_slice #(
      .NUM_LINES (NUM_LINES)
    ) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (mask_we[n]),
      .wdata   (req_wdata[NUM_LINES-1:0]),
      .raw_d   (raw_d),
      .raw_q   (raw_q),
      .mask_q  (mask_arr[n]),
      .req_q   (req_arr[n]),
      .irq_q   (cpu_irq[n])
    );
  end

  always_comb begin
    case (kind)
      RK_MASK: rdata = DATA_W'(mask_arr[cpu_sel]);
      RK_REQ:  rdata = DATA_W'(req_arr[cpu_sel]);
      RK_RAW:  rdata = DATA_W'(raw_q);
      RK_ERR:  rdata = DATA_W'(err_q);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (acc) begin
        rsp_valid <= 1'b1;
        rsp_data  <= (req_write || !legal) ? '0 : rdata;
        rsp_err   <= !legal;
        if (!legal) err_q <= 1'b1;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R7: a short access is answered with an error
  a_r7_size_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_size != SZ_DWORD)) |=> rsp_err);

  // R8: an illegal access leaves every mask untouched
  a_r8_masks_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !legal) |=> (mask_arr == $past(mask_arr)));

  // R9: the error flag never falls outside reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R10: a stalled response is held unchanged
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd3;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;
  logic        rsp_err;
  logic        line_set = 1'b0;
  logic [5:0]  line_set_idx = '0;
  logic        line_clr = 1'b0;
  logic [5:0]  line_clr_idx = '0;
  logic [3:0]  cpu_irq;

  always #10 clk = ~clk;

  irq_router u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_size, .req_addr,
    .req_wdata, .rsp_valid, .rsp_ready, .rsp_data, .rsp_err, .line_set,
    .line_set_idx, .line_clr, .line_clr_idx, .cpu_irq
  );

  typedef struct {
    logic [63:0] data;
    logic        err;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails = 0;
  bit          stall = 1'b0;
  int          cyc = 0;
  logic [63:0] mask_m [4];
  logic [63:0] raw_m = '0;
  logic        err_m = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_read(input int idx);
    if (idx < 4)  return mask_m[idx];
    if (idx < 8)  return mask_m[idx-4] & raw_m;
    if (idx == 8) return raw_m;
    return {63'b0, err_m};
  endfunction

  // driver: predicts the response, queues it, then drives the request
  task automatic access(input bit wr, input int idx, input logic [1:0] sz,
                        input logic [63:0] wd, input logic [5:0] low,
                        input string tag);
    exp_t e;
    bit   ok;
    ok = (sz == 2'd3) && (idx <= 9) && (!wr || idx < 4);
    e.tag  = tag;
    e.err  = !ok;
    e.data = (ok && !wr) ? model_read(idx) : 64'd0;
    sb.push_back(e);
    if (!ok) err_m = 1'b1;
    else if (wr) mask_m[idx] = wd;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_size  = sz;
    req_addr  = {idx[5:0], low};
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic dev(input bit s, input int si, input bit c, input int ci);
    @(negedge clk);
    line_set = s; line_set_idx = si[5:0];
    line_clr = c; line_clr_idx = ci[5:0];
    @(negedge clk);
    line_set = 1'b0; line_clr = 1'b0;
    if (c) raw_m[ci] = 1'b0;
    if (s) raw_m[si] = 1'b1;
  endtask

  task automatic chk_irq(input string req);
    logic [3:0] e;
    for (int n = 0; n < 4; n++) e[n] = |(mask_m[n] & raw_m);
    chk(cpu_irq == e, req, {60'd0, cpu_irq}, {60'd0, e});
  endtask

  // monitor: owns rsp_ready and scores each handshake
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rsp_ready = stall ? (cyc % 3 == 2) : 1'b1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R10 unexpected response", rsp_data, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_data == e.data && rsp_err == e.err, e.tag,
              {rsp_err, rsp_data[62:0]}, {e.err, e.data[62:0]});
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < 4; n++) mask_m[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cpu_irq == 4'd0, "R1 irq after reset", {60'd0, cpu_irq}, 64'd0);
    chk(req_ready && !rsp_valid, "R1 handshake idle", {62'd0, req_ready, rsp_valid}, 64'd2);
    for (int i = 0; i <= 9; i++) access(1'b0, i, 2'd3, 64'd0, 6'd0, "R1 reset read");
    drain();

    // R2 mask writes, low address bits ignored
    access(1'b1, 0, 2'd3, 64'h0000_0000_0000_00F0, 6'd0,  "R10 write data zero");
    access(1'b1, 1, 2'd3, 64'h0000_0000_0000_0001, 6'h08, "R2 mask1 write offset");
    access(1'b1, 3, 2'd3, 64'h8000_0000_0000_0010, 6'h3F, "R2 mask3 write");
    access(1'b0, 1, 2'd3, 64'd0, 6'h21, "R2 mask1 read");
    access(1'b0, 3, 2'd3, 64'd0, 6'd0,  "R2 mask3 read");
    drain();

    // R4/R6 raise line 4: CPUs 0 and 3 enabled
    dev(1'b1, 4, 1'b0, 0);
    chk(cpu_irq == 4'd0, "R6 one cycle latency", {60'd0, cpu_irq}, 64'd0);
    @(negedge clk);
    chk_irq("R6 line raise posts");
    access(1'b0, 8, 2'd3, 64'd0, 6'd0, "R4 raw after set");
    access(1'b0, 4, 2'd3, 64'd0, 6'd0, "R3 req0");
    access(1'b0, 7, 2'd3, 64'd0, 6'd0, "R3 req3");
    drain();

    // R6 line 0 reaches CPU1 only
    dev(1'b1, 0, 1'b0, 0);
    @(negedge clk);
    chk_irq("R6 line0 to cpu1");

    // R6 mask clear withdraws CPU0
    access(1'b1, 0, 2'd3, 64'd0, 6'd0, "R6 mask0 clear");
    drain();
    chk_irq("R6 withdraw on mask clear");

    // R6 mask enable for a pending line posts CPU2
    access(1'b1, 2, 2'd3, 64'h10, 6'd0, "R6 mask2 enable");
    drain();
    chk_irq("R6 post on mask enable");
    access(1'b0, 6, 2'd3, 64'd0, 6'd0, "R3 req2 after enable");
    drain();

    // R4 lowering line 4 drops CPUs 2 and 3
    dev(1'b0, 0, 1'b1, 4);
    @(negedge clk);
    chk_irq("R6 line lower withdraws");
    access(1'b0, 8, 2'd3, 64'd0, 6'd0, "R4 raw after clear");
    drain();

    // R5 spurious clear of line 63
    dev(1'b0, 0, 1'b1, 63);
    @(negedge clk);
    chk_irq("R5 spurious irq");
    access(1'b0, 8, 2'd3, 64'd0, 6'd0, "R5 raw unchanged");
    access(1'b0, 5, 2'd3, 64'd0, 6'd0, "R5 req1 unchanged");
    drain();

    // R4 set and clear of the same line: set wins
    dev(1'b1, 5, 1'b1, 5);
    access(1'b0, 8, 2'd3, 64'd0, 6'd0, "R4 set wins");
    drain();

    // R7/R8/R9 illegal accesses
    access(1'b0, 9, 2'd3, 64'd0, 6'd0, "R9 flag clear before error");
    access(1'b1, 3, 2'd2, 64'hFFFF, 6'd0, "R7 short write refused");
    access(1'b0, 3, 2'd0, 64'd0, 6'd0, "R7 short read refused");
    access(1'b0, 3, 2'd3, 64'd0, 6'd0, "R8 mask3 kept");
    access(1'b1, 4, 2'd3, 64'hFF, 6'd0, "R8 write to request");
    access(1'b1, 8, 2'd3, 64'hFF, 6'd0, "R8 write to raw");
    access(1'b0, 12, 2'd3, 64'd0, 6'd0, "R8 unmapped read");
    access(1'b0, 8, 2'd3, 64'd0, 6'd0, "R8 raw kept");
    access(1'b1, 1, 2'd3, 64'h3, 6'd0, "R9 legal write after error");
    access(1'b0, 9, 2'd3, 64'd0, 6'd0, "R9 flag sticky");
    drain();
    chk_irq("R8 irq after illegal");

    // R10 back-pressure: responses in order under stalls
    stall = 1'b1;
    for (int i = 0; i < 10; i++) access(1'b0, i % 10, 2'd3, 64'd0, 6'd0, "R10 stalled read");
    access(1'b1, 2, 2'd3, 64'h21, 6'd0, "R10 stalled write");
    access(1'b0, 2, 2'd3, 64'd0, 6'd0, "R10 read after stalled write");
    drain();
    stall = 1'b0;
    @(negedge clk);
    chk(sb.size() == 0, "R10 queue empty", 64'(sb.size()), 64'd0);
    chk_irq("R6 final irq");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule